// File: doc/BRIEF.md
# Daisy-Chain Serializer Reader with Per-Device Diagnostics

This block is a host-side SPI master that reads a chain of eight-input serializers in a single chip-select burst. The burst carries one frame per device. A frame is one data byte in short mode. In long mode it is a data byte followed by a status byte. At the end of the burst the block splits the received stream into these frames. It checks each status byte against a 5-bit CRC and its alarm bits, combines the result with the external fault pins, and publishes all input bits together with per-device diagnostic flags.

A device that shows a problem is only marked invalid in the per-device valid mask. The data of healthy devices in the same chain is still delivered. The mode and the ignore-undervoltage setting are captured when a burst starts. The fault pins are sampled when the burst ends. Every output changes in the single cycle in which the done pulse is high.

Top module: `sdi_chain_reader`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, done is 0, and in_bits, dev_valid and every flag vector are all zero.
- R2: An accepted start drives spi_cs_n low for the whole burst. spi_sclk idles low (SPI mode 0), and each of its phases lasts CLK_DIV clock cycles. MISO is sampled on each rising SCLK edge, most significant bit first. One burst has N_DEV×8×W rising edges, where W is 2 in long mode (wide_mode=1) and 1 in short mode. spi_cs_n is low for exactly 2×CLK_DIV×(bit count)+1 cycles.
- R3: Received bytes are numbered from 0 in arrival order. Device i's data byte is byte i×W. In long mode its status byte is byte i×W+1. The data byte appears on in_bits[8i+7:8i].
- R4: In long mode, crc_err[i] is set when status bits 7:3 differ from the CRC-5 of the data byte. The CRC uses polynomial x^5+x^4+x^2+1, starts from zero, and takes the data bits MSB first.
- R5: In long mode, over_temp[i] equals status bit 1, uv_alarm[i] is the inverse of status bit 2, and uv_warn[i] is the inverse of status bit 0.
- R6: dev_valid[i] is 0 exactly when at least one of fault_flag[i], crc_err[i], over_temp[i] or uv_alarm[i] is set. An undervoltage warning on its own leaves the device valid.
- R7: When ignore_uv was 1 at start, uv_alarm, uv_warn and fault_flag are all zero whatever the status bytes and the fault pins hold.
- R8: In short mode, crc_err, over_temp, uv_alarm and uv_warn are zero, and fault_flag[i] (an active-high pin) is the only reason for invalidation.
- R9: With FAULT_W=1 the single fault pin applies to every device. With FAULT_W=N_DEV, pin i applies to device i only.
- R10: done is a one-cycle pulse that comes in the same cycle spi_cs_n returns high. in_bits and all flag and valid outputs change only in a cycle where done is 1.
- R11: A start strobe that arrives while a burst is in progress is ignored. No second burst and no extra done pulse follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request strobe |
| wide_mode | input | 1 | 1 selects long frames (data plus status), 0 selects short frames |
| ignore_uv | input | 1 | Disregard undervoltage bits and fault pins |
| fault_in | input | FAULT_W | Active-high device fault pins, shared or one per device |
| spi_miso | input | 1 | Serial data from the chain |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| in_bits | output | N_DEV×8 | Input bits of all devices |
| dev_valid | output | N_DEV | Device data is free of faults |
| crc_err | output | N_DEV | Status CRC mismatch |
| over_temp | output | N_DEV | Overtemperature alarm |
| uv_alarm | output | N_DEV | Undervoltage alarm |
| uv_warn | output | N_DEV | Undervoltage warning |
| fault_flag | output | N_DEV | Fault pin seen at end of burst |
| done | output | 1 | One-cycle result strobe |

## Verification
The long-mode sweep runs all 256 data values through the first device, which always carries a matching CRC and clean status. This separates a wrong CRC polynomial or bit order from byte-position errors. The second device in the same burst gets a rotating mix of CRC corruption, alarm bits and fault-pin states, so that invalidating a faulty device without disturbing its healthy neighbour is checked on every pattern. The same frames go to two instances, one with a shared fault pin and one with a pin per device, which tells the two pin routings apart. Short-mode and ignore-undervoltage sweeps show that status-derived flags vanish while frame positions move. A mid-burst start strobe and post-burst input changes check that the outputs stay frozen between done pulses.

// File: rtl/sdi_chain_pkg.sv
package sdi_chain_pkg;

    // Per-device diagnostic result
    typedef struct packed {
        logic crc_err;
        logic over_temp;
        logic uv_alarm;
        logic uv_warn;
        logic fault;
        logic valid;
    } dev_diag_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_FINISH
    } eng_state_e;

    localparam logic [4:0] CRC5_POLY = 5'h15;  // x^5 + x^4 + x^2 + 1

    // Bit-serial CRC-5 over one byte, MSB first, zero seed
    function automatic logic [4:0] crc5_byte(input logic [7:0] data);
        logic [4:0] c;
        logic       fb;
        c = '0;
        for (int b = 7; b >= 0; b--) begin
            fb = c[4] ^ data[b];
            c  = {c[3:0], 1'b0};
            if (fb) c = c ^ CRC5_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdi_shift_engine.sv
module sdi_shift_engine
    import sdi_chain_pkg::*;
#(
    parameter int N_DEV   = 2,
    parameter int CLK_DIV = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        wide_mode,
    input  logic                        miso,
    output logic                        cs_n,
    output logic                        sclk,
    output logic                        accept,
    output logic                        finish,
    output logic                        wide_q,
    output logic [2*N_DEV-1:0][7:0]     rx_bytes
);
    localparam int NBYTES = 2 * N_DEV;
    localparam int BITW   = $clog2(NBYTES * 8 + 1);
    localparam int DIVW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [BITW-1:0] LAST_LONG  = BITW'(NBYTES * 8 - 1);
    localparam logic [BITW-1:0] LAST_SHORT = BITW'(N_DEV * 8 - 1);
    localparam logic [DIVW-1:0] DIV_END    = DIVW'(CLK_DIV - 1);

    eng_state_e      state;
    logic [DIVW-1:0] div_cnt;
    logic [BITW-1:0] bit_cnt;
    logic [6:0]      shreg;
    logic [BITW-1:0] last_bit;

    assign last_bit = wide_q ? LAST_LONG : LAST_SHORT;
    assign accept   = start && (state == ENG_IDLE);
    assign finish   = (state == ENG_FINISH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            div_cnt  <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            wide_q   <= 1'b0;
            rx_bytes <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state   <= ENG_SHIFT;
                        cs_n    <= 1'b0;
                        sclk    <= 1'b0;
                        div_cnt <= '0;
                        bit_cnt <= '0;
                        wide_q  <= wide_mode;
                    end
                end
                ENG_SHIFT: begin
                    if (div_cnt == DIV_END) begin
                        div_cnt <= '0;
                        sclk    <= ~sclk;
                        if (!sclk) begin
                            // rising edge: capture one bit
                            shreg <= {shreg[5:0], miso};
                            if (bit_cnt[2:0] == 3'd7)
                                rx_bytes[bit_cnt[BITW-1:3]] <= {shreg, miso};
                        end else begin
                            // falling edge: advance or close the burst
                            if (bit_cnt == last_bit) state <= ENG_FINISH;
                            else                     bit_cnt <= bit_cnt + 1'b1;
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ENG_FINISH: begin
                    cs_n  <= 1'b1;
                    state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdi_frame_check.sv
module sdi_frame_check
    import sdi_chain_pkg::*;
(
    input  logic       wide,
    input  logic       ign_uv,
    input  logic       fault_pin,
    input  logic [7:0] data_byte,
    input  logic [7:0] status_byte,
    output dev_diag_t  diag
);
    logic [4:0] crc_calc;

    assign crc_calc = crc5_byte(data_byte);

    always_comb begin
        diag.crc_err   = wide && (status_byte[7:3] != crc_calc);
        diag.over_temp = wide && status_byte[1];
        diag.uv_alarm  = wide && !ign_uv && !status_byte[2];
        diag.uv_warn   = wide && !ign_uv && !status_byte[0];
        diag.fault     = !ign_uv && fault_pin;
        diag.valid     = !(diag.crc_err || diag.over_temp ||
                           diag.uv_alarm || diag.fault);
    end
endmodule

// File: rtl/sdi_chain_reader.sv
module sdi_chain_reader
    import sdi_chain_pkg::*;
#(
    parameter int N_DEV   = 2,
    parameter int CLK_DIV = 2,
    parameter int FAULT_W = N_DEV
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 wide_mode,
    input  logic                 ignore_uv,
    input  logic [FAULT_W-1:0]   fault_in,
    input  logic                 spi_miso,
    output logic                 spi_sclk,
    output logic                 spi_cs_n,
    output logic [N_DEV*8-1:0]   in_bits,
    output logic [N_DEV-1:0]     dev_valid,
    output logic [N_DEV-1:0]     crc_err,
    output logic [N_DEV-1:0]     over_temp,
    output logic [N_DEV-1:0]     uv_alarm,
    output logic [N_DEV-1:0]     uv_warn,
    output logic [N_DEV-1:0]     fault_flag,
    output logic                 done
);
    logic                     accept;
    logic                     finish;
    logic                     wide_q;
    logic                     ign_q;
    logic [2*N_DEV-1:0][7:0]  rx_bytes;
    logic [N_DEV-1:0][7:0]    data_w;
    dev_diag_t                diag [N_DEV];

    sdi_shift_engine #(
        .N_DEV   (N_DEV),
        .CLK_DIV (CLK_DIV)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wide_mode (wide_mode),
        .miso      (spi_miso),
        .cs_n      (spi_cs_n),
        .sclk      (spi_sclk),
        .accept    (accept),
        .finish    (finish),
        .wide_q    (wide_q),
        .rx_bytes  (rx_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst)         ign_q <= 1'b0;
        else if (accept) ign_q <= ignore_uv;
    end

    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
        logic pin;
        if (FAULT_W == 1) begin : g_shared
            assign pin = fault_in[0];
        end else begin : g_each
            assign pin = fault_in[i];
        end

        assign data_w[i] = wide_q ? rx_bytes[2*i] : rx_bytes[i];

        sdi_frame_check u_check (
            .wide        (wide_q),
            .ign_uv      (ign_q),
            .fault_pin   (pin),
            .data_byte   (data_w[i]),
            .status_byte (rx_bytes[2*i+1]),
            .diag        (diag[i])
        );
    end

    // Result bank: every output commits together with done
    always_ff @(posedge clk) begin
        if (rst) begin
            in_bits    <= '0;
            dev_valid  <= '0;
            crc_err    <= '0;
            over_temp  <= '0;
            uv_alarm   <= '0;
            uv_warn    <= '0;
            fault_flag <= '0;
            done       <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                for (int i = 0; i < N_DEV; i++) begin
                    in_bits[8*i +: 8] <= data_w[i];
                    dev_valid[i]      <= diag[i].valid;
                    crc_err[i]        <= diag[i].crc_err;
                    over_temp[i]      <= diag[i].over_temp;
                    uv_alarm[i]       <= diag[i].uv_alarm;
                    uv_warn[i]        <= diag[i].uv_warn;
                    fault_flag[i]     <= diag[i].fault;
                end
            end
        end
    end
endmodule

// File: rtl/sdi_chain_reader_chk.sv
module sdi_chain_reader_chk #(
    parameter int N_DEV = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               spi_sclk,
    input logic               spi_cs_n,
    input logic [N_DEV*8-1:0] in_bits,
    input logic [N_DEV-1:0]   dev_valid,
    input logic [N_DEV-1:0]   crc_err,
    input logic [N_DEV-1:0]   over_temp,
    input logic [N_DEV-1:0]   uv_alarm,
    input logic [N_DEV-1:0]   uv_warn,
    input logic [N_DEV-1:0]   fault_flag,
    input logic               done
);
    logic [N_DEV*6-1:0] flag_bank;
    assign flag_bank = {dev_valid, crc_err, over_temp, uv_alarm, uv_warn, fault_flag};

    // R2: clock idles low outside a burst
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R10: chip select releases together with the result strobe
    assert_cs_release_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> done);

    // R10: strobe lasts one cycle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: strobe only outside a burst
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> spi_cs_n);

    // R10: data bank moves only with done
    assert_atomic_data_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(in_bits) |-> done);

    // R10: flag bank moves only with done
    assert_atomic_flags_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(flag_bank) |-> done);

    // R6: a valid device carries no invalidating flag
    assert_valid_clean_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ((dev_valid & (crc_err | over_temp | uv_alarm | fault_flag)) == '0));
endmodule

bind sdi_chain_reader sdi_chain_reader_chk #(.N_DEV(N_DEV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .in_bits    (in_bits),
    .dev_valid  (dev_valid),
    .crc_err    (crc_err),
    .over_temp  (over_temp),
    .uv_alarm   (uv_alarm),
    .uv_warn    (uv_warn),
    .fault_flag (fault_flag),
    .done       (done)
);

// File: tb/tb_sdi_chain_reader.sv
module tb_chain_slave #(
    parameter int FW = 32
) (
    input  logic          cs_n,
    input  logic          sclk,
    input  logic [FW-1:0] frame,
    output logic          miso
);
    int idx = 0;
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) idx <= 0;
        else      idx <= idx + 1;
    end
    assign miso = (idx < FW) ? frame[FW-1-idx] : 1'b0;
endmodule

module tb_sdi_chain_reader;
    localparam int N  = 2;
    localparam int D  = 2;
    localparam int FW = 2 * N * 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;  // 250 MHz

    logic         start = 1'b0;
    logic         wide_mode = 1'b1;
    logic         ignore_uv = 1'b0;
    logic [N-1:0] fault_vec = '0;
    logic         fault_sh = 1'b0;
    logic [FW-1:0] frame = '0;

    logic          miso_a, miso_b;
    logic          sclk_a, cs_a, sclk_b, cs_b;
    logic [N*8-1:0] bits_a, bits_b;
    logic [N-1:0]  val_a, crc_a, ot_a, uva_a, uvw_a, flt_a;
    logic [N-1:0]  val_b, crc_b, ot_b, uva_b, uvw_b, flt_b;
    logic          done_a, done_b;

    sdi_chain_reader #(.N_DEV(N), .CLK_DIV(D), .FAULT_W(N)) dut (
        .clk(clk), .rst(rst), .start(start), .wide_mode(wide_mode),
        .ignore_uv(ignore_uv), .fault_in(fault_vec), .spi_miso(miso_a),
        .spi_sclk(sclk_a), .spi_cs_n(cs_a), .in_bits(bits_a),
        .dev_valid(val_a), .crc_err(crc_a), .over_temp(ot_a),
        .uv_alarm(uva_a), .uv_warn(uvw_a), .fault_flag(flt_a), .done(done_a));

    sdi_chain_reader #(.N_DEV(N), .CLK_DIV(D), .FAULT_W(1)) dut_sh (
        .clk(clk), .rst(rst), .start(start), .wide_mode(wide_mode),
        .ignore_uv(ignore_uv), .fault_in(fault_sh), .spi_miso(miso_b),
        .spi_sclk(sclk_b), .spi_cs_n(cs_b), .in_bits(bits_b),
        .dev_valid(val_b), .crc_err(crc_b), .over_temp(ot_b),
        .uv_alarm(uva_b), .uv_warn(uvw_b), .fault_flag(flt_b), .done(done_b));

    tb_chain_slave #(.FW(FW)) u_sl_a (.cs_n(cs_a), .sclk(sclk_a), .frame(frame), .miso(miso_a));
    tb_chain_slave #(.FW(FW)) u_sl_b (.cs_n(cs_b), .sclk(sclk_b), .frame(frame), .miso(miso_b));

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // Burst observation counters
    int cs_low_cnt = 0;
    int rise_cnt   = 0;
    int done_cnt   = 0;
    logic sclk_prev = 1'b0;
    always @(negedge clk) begin
        if (cs_a === 1'b0) cs_low_cnt <= cs_low_cnt + 1;
        if (sclk_a === 1'b1 && sclk_prev === 1'b0) rise_cnt <= rise_cnt + 1;
        if (done_a === 1'b1) done_cnt <= done_cnt + 1;
        sclk_prev <= sclk_a;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] crc_ref(input logic [7:0] d);
        logic [7:0] c;
        c = d;
        for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'hA8) : (c << 1);
        return c[7:3];
    endfunction

    // Expected results for one instance
    logic [N*8-1:0] e_bits;
    logic [N-1:0]   e_val, e_crc, e_ot, e_uva, e_uvw, e_flt;

    task automatic expect_calc(input logic [2*N-1:0][7:0] b, input bit wide,
                               input bit ign, input logic [N-1:0] pins);
        int wl;
        logic [7:0] dat, st;
        wl = wide ? 2 : 1;
        for (int i = 0; i < N; i++) begin
            dat = b[i*wl];
            st  = b[2*i+1];
            e_bits[8*i +: 8] = dat;
            e_crc[i] = wide && (st[7:3] != crc_ref(dat));
            e_ot[i]  = wide && st[1];
            e_uva[i] = wide && !ign && !st[2];
            e_uvw[i] = wide && !ign && !st[0];
            e_flt[i] = !ign && pins[i];
            e_val[i] = !(e_crc[i] | e_ot[i] | e_uva[i] | e_flt[i]);
        end
    endtask

    task automatic check_inst(input bit sh, input bit wide, input bit ign);
        logic [N*8-1:0] ab;
        logic [N-1:0] av, ac, ao, aa, aw, af;
        string pfx;
        pfx = sh ? "shared-pin" : "per-pin";
        ab = sh ? bits_b : bits_a;  av = sh ? val_b : val_a;
        ac = sh ? crc_b : crc_a;    ao = sh ? ot_b : ot_a;
        aa = sh ? uva_b : uva_a;    aw = sh ? uvw_b : uvw_a;
        af = sh ? flt_b : flt_a;
        chk(ab == e_bits, {pfx, " R3 data bytes"}, 64'(ab), 64'(e_bits));
        chk(ac == e_crc, {pfx, " R4 crc"}, 64'(ac), 64'(e_crc));
        chk({ao, aa, aw} == {e_ot, e_uva, e_uvw}, {pfx, " R5 status alarms"},
            64'({ao, aa, aw}), 64'({e_ot, e_uva, e_uvw}));
        chk(av == e_val, {pfx, " R6 valid mask"}, 64'(av), 64'(e_val));
        chk(af == e_flt, {pfx, " R9 fault routing"}, 64'(af), 64'(e_flt));
        if (ign)
            chk({aa, aw, af} == '0, {pfx, " R7 ignore-uv clears"}, 64'({aa, aw, af}), 64'(0));
        if (!wide)
            chk({ac, ao, aa, aw} == '0, {pfx, " R8 short mode flags"}, 64'({ac, ao, aa, aw}), 64'(0));
    endtask

    task automatic run_xfer(input logic [2*N-1:0][7:0] b, input bit wide, input bit ign,
                            input logic [N-1:0] pins, input bit psh, input bit extra_start);
        int t;
        int nbits;
        for (int k = 0; k < 2*N; k++) frame[FW-1-8*k -: 8] = b[k];
        wide_mode = wide; ignore_uv = ign; fault_vec = pins; fault_sh = psh;
        @(negedge clk);
        cs_low_cnt = 0; rise_cnt = 0; done_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (done_a !== 1'b1 && t < 3000) begin
            @(negedge clk);
            t++;
            if (extra_start && t == 40) start = 1'b1;
            if (extra_start && t == 41) start = 1'b0;
        end
        chk(t < 3000, "R10 done seen", 64'(t), 64'(0));
        chk(done_b === 1'b1, "R10 both instances done together", 64'(done_b), 64'(1));
        nbits = N * 8 * (wide ? 2 : 1);
        chk(rise_cnt == nbits, "R2 sclk rising edges", 64'(rise_cnt), 64'(nbits));
        chk(cs_low_cnt == nbits*2*D + 1, "R2 cs low duration", 64'(cs_low_cnt), 64'(nbits*2*D+1));
        expect_calc(b, wide, ign, pins);
        check_inst(1'b0, wide, ign);
        expect_calc(b, wide, ign, {N{psh}});
        check_inst(1'b1, wide, ign);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [2*N-1:0][7:0] b;
        logic [N*8-1:0] hold_bits;
        logic [N-1:0]   hold_val, hold_flt, hold_uvw;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cs_a === 1'b1 && sclk_a === 1'b0 && done_a === 1'b0, "R1 idle pins",
            64'({cs_a, sclk_a, done_a}), 64'(3'b100));
        chk({bits_a, val_a, crc_a, ot_a, uva_a, uvw_a, flt_a} == '0, "R1 result bank zero",
            64'({bits_a, val_a, crc_a, ot_a, uva_a, uvw_a, flt_a}), 64'(0));

        // Long frames: device 0 sweeps every data value cleanly,
        // device 1 carries rotating corruption and alarms
        for (int v = 0; v < 256; v++) begin
            logic [7:0] d0, d1;
            logic [4:0] c1;
            d0 = 8'(v);
            d1 = d0 ^ 8'h5A;
            c1 = crc_ref(d1) ^ (v[7] ? (5'h01 << v[6:5]) : 5'h00);
            b[0] = d0;
            b[1] = {crc_ref(d0), 3'b101};
            b[2] = d1;
            b[3] = {c1, d0[2:0]};
            run_xfer(b, 1'b1, 1'b0, {v[4] & v[3], 1'b0}, &d0[7:5], 1'b0);
        end

        // Short frames: status positions unused, only fault pins matter
        for (int v = 0; v < 64; v++) begin
            b[0] = 8'(v * 3);
            b[1] = ~8'(v);
            b[2] = 8'hFF;
            b[3] = 8'h00;
            run_xfer(b, 1'b0, 1'b0, 2'(v), v[2], 1'b0);
        end

        // Ignore-undervoltage: alarms on status and pins must vanish
        for (int v = 0; v < 64; v++) begin
            b[0] = 8'(v ^ 8'hC3);
            b[1] = {crc_ref(8'(v ^ 8'hC3)), 1'b0, v[0], 1'b0};
            b[2] = 8'(v);
            b[3] = {crc_ref(8'(v)) ^ {4'b0, v[5]}, 3'b000};
            run_xfer(b, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0);
        end

        // R11: start strobe during a burst
        b[0] = 8'hA5; b[1] = {crc_ref(8'hA5), 3'b101};
        b[2] = 8'h3C; b[3] = {crc_ref(8'h3C), 3'b100};
        run_xfer(b, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1);
        repeat (300) @(negedge clk);
        chk(done_cnt == 1, "R11 single done after mid-burst start", 64'(done_cnt), 64'(1));
        chk(cs_a === 1'b1, "R11 no second burst", 64'(cs_a), 64'(1));
        chk(val_a == 2'b11 && uvw_a == 2'b10, "R6 warning alone keeps valid",
            64'({val_a, uvw_a}), 64'(4'b1110));

        // R10: inputs changing after done leave the bank untouched
        hold_bits = bits_a; hold_val = val_a; hold_flt = flt_a; hold_uvw = uvw_a;
        fault_vec = 2'b11; fault_sh = 1'b1; ignore_uv = 1'b1; wide_mode = 1'b0;
        repeat (60) @(negedge clk);
        chk({bits_a, val_a, flt_a, uvw_a} == {hold_bits, hold_val, hold_flt, hold_uvw},
            "R10 outputs hold between bursts",
            64'({bits_a, val_a, flt_a, uvw_a}), 64'({hold_bits, hold_val, hold_flt, hold_uvw}));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule